// File: doc/BRIEF.md
# Byte Parity Generator and Checker

This block sits between a memory controller and a 32-bit storage array that keeps one parity bit beside every data byte. During a write it computes an odd parity bit for each byte of the write data and raises separate data and parity write enables for exactly the byte lanes the access selects. Unselected lanes keep whatever the array already holds.

During a read the block examines all four stored bytes against their stored parity bits, whatever width the requester asked for. If checking is switched on and any lane fails, it records one error per read cycle. The error goes to one of two outputs chosen by the cycle type: the host parity error line for processor cycles, or the system-bus error response for system-bus cycles. Refresh cycles never report an error. The recorded error appears one clock after the read sample strobe and holds until the next cycle starts, which gives it a defined valid window.

Top module: `byte_parity_guard`

## Requirements
- R1: During an active write, parity bit i (`wr_par[i]`) is the odd parity of byte lane i, `wr_data[8i+7:8i]`: the byte and its parity bit together hold an odd number of ones.
- R2: Write parity is produced the same way whether `check_en` is high or low.
- R3: During an active write cycle (`cyc_act`=1, `cyc_write`=1) of kind host (`cyc_kind`=2'b00) or system bus (2'b01), `data_we` and `par_we` both equal `lane_sel`. Bit i of `lane_sel` selects byte lane i. In every other case both enables are all zero.
- R4: A read checks all four lanes, whatever `lane_sel` holds. A parity failure in an unselected lane still reports an error.
- R5: When `check_en` is low, a read never raises either error output.
- R6: A failing read on a host cycle (`cyc_kind`=2'b00) sets `host_perr` and leaves `sys_berr` low.
- R7: A failing read on a system-bus cycle (`cyc_kind`=2'b01) sets `sys_berr` and leaves `host_perr` low.
- R8: The error is registered on the clock edge where `rd_sample` is high and shows on the outputs one cycle later. It holds through the end of the cycle and clears on the edge where `cyc_start` is next seen high.
- R9: Refresh cycles (`cyc_kind`=2'b10 or 2'b11) never raise an error and never assert a write enable.
- R10: After synchronous active-low reset, both error outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| check_en | input | 1 | Static read-check enable, normally tied high |
| cyc_start | input | 1 | One-clock pulse at the start of each memory cycle |
| cyc_act | input | 1 | High while a memory cycle is active |
| cyc_kind | input | 2 | 00 host, 01 system bus, 10/11 refresh |
| cyc_write | input | 1 | 1 for a write cycle, 0 for a read |
| lane_sel | input | 4 | Decoded byte-lane select, bit i selects lane i |
| wr_data | input | 32 | Write data |
| wr_par | output | 4 | Odd parity bits to store, one per lane |
| data_we | output | 4 | Per-lane data write enables |
| par_we | output | 4 | Per-lane parity write enables |
| rd_data | input | 32 | Data read from the array |
| rd_par | input | 4 | Parity bits read from the array |
| rd_sample | input | 1 | Pulse when the read data and parity are valid |
| host_perr | output | 1 | Host parity error flag |
| sys_berr | output | 1 | System-bus error flag |

## Verification
The bench corrupts a lane that the read did not select. A design that checks only the requested bytes would stay silent there. It sends the same faulty data on host, system-bus and refresh cycles, so a design that swaps or merges the two error outputs, or that flags refresh, shows up as a wrong output. It also sends a faulty read with checking off, and writes with checking off, so that any coupling between the enable and parity generation is caught. It then watches the flag across the end of the cycle and at the next cycle start, which catches a flag that clears too early or never clears.

// File: rtl/bpg_pkg.sv
// Shared sizes and cycle-type encoding for the byte parity guard.
package bpg_pkg;
    localparam int LANES  = 4;
    localparam int LANE_W = 8;
    localparam int DATA_W = LANES * LANE_W;

    typedef enum logic [1:0] {
        KIND_HOST = 2'b00,
        KIND_SYS  = 2'b01,
        KIND_REF  = 2'b10,
        KIND_REF2 = 2'b11
    } cyc_kind_e;
endpackage

// File: rtl/bpg_wr_lanes.sv
// Write side: odd parity per byte lane and per-lane write enables.
// Assumes lane_sel is already decoded from width and address by the requester.
module bpg_wr_lanes #(
    parameter int LANES  = bpg_pkg::LANES,
    parameter int LANE_W = bpg_pkg::LANE_W,
    localparam int DW    = LANES * LANE_W
) (
    input  logic             cyc_act,
    input  logic             cyc_write,
    input  logic [1:0]       cyc_kind,
    input  logic [LANES-1:0] lane_sel,
    input  logic [DW-1:0]    wr_data,
    output logic [LANES-1:0] wr_par,
    output logic [LANES-1:0] data_we,
    output logic [LANES-1:0] par_we
);
    logic wr_go;

    // Writes are live only on non-refresh active write cycles.
    always_comb begin
        wr_go = cyc_act && cyc_write && !cyc_kind[1];
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        // Parity bit that makes the stored byte plus parity odd.
        always_comb begin
            wr_par[i]  = ~^wr_data[i*LANE_W +: LANE_W];
            data_we[i] = wr_go && lane_sel[i];
            par_we[i]  = wr_go && lane_sel[i];
        end
    end
endmodule

// File: rtl/bpg_rd_check.sv
// Read side: checks every lane against its stored parity, whatever width was asked.
// Assumes rd_data and rd_par are valid while rd_sample is high.
module bpg_rd_check #(
    parameter int LANES  = bpg_pkg::LANES,
    parameter int LANE_W = bpg_pkg::LANE_W,
    localparam int DW    = LANES * LANE_W
) (
    input  logic [DW-1:0]    rd_data,
    input  logic [LANES-1:0] rd_par,
    output logic             any_bad
);
    logic [LANES-1:0] lane_bad;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        // A lane is bad when byte plus parity has an even count of ones.
        always_comb begin
            lane_bad[i] = ~(^{rd_data[i*LANE_W +: LANE_W], rd_par[i]});
        end
    end

    // Any failing lane fails the whole longword.
    always_comb begin
        any_bad = |lane_bad;
    end
endmodule

// File: rtl/bpg_err_route.sv
// Registers one error result per read and routes it by cycle type.
// Assumes cyc_kind is stable across the read sample.
module bpg_err_route (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       check_en,
    input  logic       cyc_start,
    input  logic       cyc_act,
    input  logic       cyc_write,
    input  logic [1:0] cyc_kind,
    input  logic       rd_sample,
    input  logic       any_bad,
    output logic       host_perr,
    output logic       sys_berr
);
    import bpg_pkg::*;

    logic fail_now;

    // A read failure counts only when checking is on and the cycle is not a refresh.
    always_comb begin
        fail_now = check_en && cyc_act && !cyc_write && !cyc_kind[1] && any_bad;
    end

    // Capture on the sample, clear on the next cycle start, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_perr <= 1'b0;
            sys_berr  <= 1'b0;
        end else if (rd_sample) begin
            host_perr <= fail_now && (cyc_kind == KIND_HOST);
            sys_berr  <= fail_now && (cyc_kind == KIND_SYS);
        end else if (cyc_start) begin
            host_perr <= 1'b0;
            sys_berr  <= 1'b0;
        end
    end
endmodule

// File: rtl/byte_parity_guard.sv
// Top: byte parity generation on writes, full-longword checking on reads,
// error routed to the host or system-bus output by cycle type.
module byte_parity_guard #(
    parameter int LANES  = bpg_pkg::LANES,
    parameter int LANE_W = bpg_pkg::LANE_W,
    localparam int DW    = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             check_en,
    input  logic             cyc_start,
    input  logic             cyc_act,
    input  logic [1:0]       cyc_kind,
    input  logic             cyc_write,
    input  logic [LANES-1:0] lane_sel,
    input  logic [DW-1:0]    wr_data,
    output logic [LANES-1:0] wr_par,
    output logic [LANES-1:0] data_we,
    output logic [LANES-1:0] par_we,
    input  logic [DW-1:0]    rd_data,
    input  logic [LANES-1:0] rd_par,
    input  logic             rd_sample,
    output logic             host_perr,
    output logic             sys_berr
);
    logic any_bad;

    bpg_wr_lanes #(.LANES(LANES), .LANE_W(LANE_W)) u_wr (
        .cyc_act   (cyc_act),
        .cyc_write (cyc_write),
        .cyc_kind  (cyc_kind),
        .lane_sel  (lane_sel),
        .wr_data   (wr_data),
        .wr_par    (wr_par),
        .data_we   (data_we),
        .par_we    (par_we)
    );

    bpg_rd_check #(.LANES(LANES), .LANE_W(LANE_W)) u_rd (
        .rd_data (rd_data),
        .rd_par  (rd_par),
        .any_bad (any_bad)
    );

    bpg_err_route u_route (
        .clk       (clk),
        .rst_n     (rst_n),
        .check_en  (check_en),
        .cyc_start (cyc_start),
        .cyc_act   (cyc_act),
        .cyc_write (cyc_write),
        .cyc_kind  (cyc_kind),
        .rd_sample (rd_sample),
        .any_bad   (any_bad),
        .host_perr (host_perr),
        .sys_berr  (sys_berr)
    );
endmodule

// File: rtl/bpg_checker.sv
// Protocol checks on the byte parity guard ports, attached by bind.
module bpg_checker #(
    parameter int LANES = bpg_pkg::LANES
) (
    input logic             clk,
    input logic             rst_n,
    input logic             check_en,
    input logic             cyc_start,
    input logic             cyc_act,
    input logic [1:0]       cyc_kind,
    input logic             cyc_write,
    input logic [LANES-1:0] lane_sel,
    input logic [LANES-1:0] data_we,
    input logic [LANES-1:0] par_we,
    input logic             rd_sample,
    input logic             host_perr,
    input logic             sys_berr
);
    // R3: enables never reach a lane outside the selection
    always_comb begin
        a_r3_we_in_sel: assert (((data_we | par_we) & ~lane_sel) == '0);
    end

    // R9: refresh never writes
    always_comb begin
        if (cyc_kind[1]) a_r9_no_refresh_we: assert (data_we == '0 && par_we == '0);
    end

    // R6 R7: only one error output at a time
    a_r7_one_err_out: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_perr && sys_berr));

    // R5: checking off gives no error
    a_r5_off_no_err: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sample && !check_en) |=> (!host_perr && !sys_berr));

    // R9: refresh reads never flag
    a_r9_refresh_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sample && cyc_kind[1]) |=> (!host_perr && !sys_berr));

    // R8: cycle start clears the flag
    a_r8_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_start && !rd_sample) |=> (!host_perr && !sys_berr));

    // R8: flag holds between sample and next start
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!cyc_start && !rd_sample) |=> ($stable(host_perr) && $stable(sys_berr)));

    // R8: host flag rises only after a host read sample
    a_r8_rise_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_perr) |-> ($past(rd_sample) && $past(cyc_kind) == 2'b00 && !$past(cyc_write) && $past(cyc_act)));
endmodule

bind byte_parity_guard bpg_checker #(.LANES(LANES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .check_en  (check_en),
    .cyc_start (cyc_start),
    .cyc_act   (cyc_act),
    .cyc_kind  (cyc_kind),
    .cyc_write (cyc_write),
    .lane_sel  (lane_sel),
    .data_we   (data_we),
    .par_we    (par_we),
    .rd_sample (rd_sample),
    .host_perr (host_perr),
    .sys_berr  (sys_berr)
);

// File: tb/byte_parity_guard_tb.sv
// Directed bench for byte_parity_guard: inputs change on the falling edge, outputs are read there.
module byte_parity_guard_tb;
    logic        clk = 1'b0;
    logic        rst_n, check_en, cyc_start, cyc_act, cyc_write, rd_sample;
    logic [1:0]  cyc_kind;
    logic [3:0]  lane_sel, rd_par, wr_par, data_we, par_we;
    logic [31:0] wr_data, rd_data;
    logic        host_perr, sys_berr;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    byte_parity_guard u_dut (
        .clk(clk), .rst_n(rst_n), .check_en(check_en), .cyc_start(cyc_start),
        .cyc_act(cyc_act), .cyc_kind(cyc_kind), .cyc_write(cyc_write),
        .lane_sel(lane_sel), .wr_data(wr_data), .wr_par(wr_par),
        .data_we(data_we), .par_we(par_we), .rd_data(rd_data), .rd_par(rd_par),
        .rd_sample(rd_sample), .host_perr(host_perr), .sys_berr(sys_berr)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Reference odd parity by counting ones.
    function automatic logic [3:0] odd_par(input logic [31:0] d);
        logic [3:0] p;
        for (int l = 0; l < 4; l++) begin
            int ones = 0;
            for (int b = 0; b < 8; b++) ones += int'(d[l*8+b]);
            p[l] = (ones % 2 == 0);
        end
        return p;
    endfunction

    task automatic idle();
        cyc_start = 0; cyc_act = 0; cyc_write = 0; rd_sample = 0;
        cyc_kind = 2'b00; lane_sel = 4'h0; wr_data = '0; rd_data = '0; rd_par = '0;
    endtask

    task automatic t_reset();
        idle(); check_en = 1; rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R10 host_perr", {31'd0, host_perr}, 0);
        check("R10 sys_berr", {31'd0, sys_berr}, 0);
    endtask

    // One write cycle; checks parity and enables combinationally.
    task automatic do_write(input logic [1:0] kind, input logic [3:0] sel, input logic [31:0] d, input string req);
        cyc_start = 1; cyc_act = 1; cyc_write = 1; cyc_kind = kind; lane_sel = sel; wr_data = d;
        #1;
        check({req, " wr_par"}, {28'd0, wr_par}, {28'd0, odd_par(d)});
        check({req, " data_we"}, {28'd0, data_we}, kind[1] ? 0 : {28'd0, sel});
        check({req, " par_we"}, {28'd0, par_we}, kind[1] ? 0 : {28'd0, sel});
        @(negedge clk);
        cyc_start = 0;
        @(negedge clk);
        idle();
        #1;
        check("R3 idle we", {28'd0, data_we | par_we}, 0);
        @(negedge clk);
    endtask

    // One read cycle with flag checks at sample+1, at the end of the cycle, and after the next start.
    task automatic do_read(input logic [1:0] kind, input logic [3:0] sel, input logic [31:0] d,
                           input logic [3:0] p, input logic exp_err, input string req);
        cyc_start = 1; cyc_act = 1; cyc_write = 0; cyc_kind = kind; lane_sel = sel;
        rd_data = d; rd_par = p;
        #1;
        check("R3 read we", {28'd0, data_we | par_we}, 0);
        @(negedge clk);
        cyc_start = 0; rd_sample = 1;
        @(negedge clk);
        rd_sample = 0;
        check({req, " host_perr"}, {31'd0, host_perr}, {31'd0, exp_err && kind == 2'b00});
        check({req, " sys_berr"}, {31'd0, sys_berr}, {31'd0, exp_err && kind == 2'b01});
        @(negedge clk);
        idle();
        @(negedge clk);
        check("R8 hold after cycle end", {31'd0, host_perr | sys_berr}, {31'd0, exp_err && !kind[1]});
        cyc_start = 1; cyc_act = 1; cyc_kind = 2'b11;
        @(negedge clk);
        check("R8 cleared at next start", {31'd0, host_perr | sys_berr}, 0);
        idle();
        @(negedge clk);
    endtask

    task automatic t_write_parity();
        do_write(2'b00, 4'hF, 32'h0000_0000, "R1 zeros");
        do_write(2'b00, 4'hF, 32'hFF01_8037, "R1 mix");
        do_write(2'b01, 4'hF, 32'hA5C3_7E12, "R1 sys");
        check_en = 0;
        do_write(2'b00, 4'hF, 32'h0102_0408, "R2 check off");
        check_en = 1;
    endtask

    task automatic t_write_lanes();
        do_write(2'b00, 4'b0001, 32'h1234_5678, "R3 byte0");
        do_write(2'b01, 4'b1100, 32'h1234_5678, "R3 upper word");
        do_write(2'b10, 4'hF, 32'h1234_5678, "R9 refresh write");
    endtask

    task automatic t_reads();
        logic [31:0] d = 32'hDEAD_BEEF;
        logic [3:0]  good = odd_par(d);
        do_read(2'b00, 4'hF, d, good, 0, "R4 clean host");
        do_read(2'b00, 4'hF, d, good ^ 4'b0010, 1, "R6 host error");
        do_read(2'b01, 4'hF, d, good ^ 4'b0100, 1, "R7 sys error");
        do_read(2'b00, 4'b0001, d, good ^ 4'b1000, 1, "R4 unselected lane");
        do_read(2'b01, 4'b0011, d, good ^ 4'b1000, 1, "R4 sys unselected");
        do_read(2'b10, 4'hF, d, ~good, 0, "R9 refresh read");
        check_en = 0;
        do_read(2'b00, 4'hF, d, ~good, 0, "R5 check off host");
        do_read(2'b01, 4'hF, d, ~good, 0, "R5 check off sys");
        check_en = 1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_write_parity();
        t_write_lanes();
        t_reads();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule